// File: doc/BRIEF.md
# Typed Control/Status Register Slave

This block is an APB4 completer that puts a small bank of typed registers behind a thin layer of bus glue. The glue watches the bus pins and merges the written bytes under the byte strobes. It decodes the word offset into one write strobe per register and selects the read data. The bank never sees raw bus signals. It receives only a compact strobe bundle and the merged write word.

Each of the four registers follows its own rules on bus reads, bus writes and hardware updates:

- The control word is plain software storage. Its value is driven out to the surrounding logic.
- The status word copies a hardware input on every clock.
- The flag word collects hardware events, and software clears bits by writing ones to them.
- The command register turns a write into a single-cycle start pulse.

An interrupt output is high whenever any flag bit is set. When a hardware event and a software clear reach the same flag bit on the same edge, the hardware set wins, so no event is lost.

Top module: `csr_slave`

## Requirements
- R1: A committed write to offset 0x0 updates only the byte lanes whose PSTRB bit is 1 and keeps the other lanes. Reads of 0x0 return the stored word, and ctrlOut always shows it.
- R2: The status word at offset 0x4 is loaded from hwStatus on every clock edge, so a read returns the value sampled at the previous edge. Bus writes to 0x4 leave it unchanged.
- R3: A committed write to offset 0x8 clears each flag bit whose merged write bit is 1, and lanes with PSTRB 0 count as zeros. Bits written as 0 are kept. Flag bits at and above EVENT_W always read 0.
- R4: If hwEvent[i] is 1 on the same edge that software clears flag bit i, the bit ends that edge set. irq is then high in the next cycle.
- R5: Each hwEvent[i] that is 1 at a clock edge sets flag bit i at that edge. irq is the OR of all flag bits.
- R6: A committed write to offset 0xC whose merged bit 0 is 1 drives cmdPulse high for exactly the one cycle after the commit edge. Any other command write gives no pulse, and a read of 0xC returns 0.
- R7: An access to any offset other than 0x0, 0x4, 0x8 or 0xC, including a misaligned one, has PSLVERR high in its access phase. It returns PRDATA 0 and changes no register.
- R8: PREADY is always 1. A write commits only on an edge where PSEL, PENABLE and PWRITE are all 1, so a setup phase alone changes nothing.
- R9: While PRESETn is low, control resets to CTRL_RESET, and status, flags and cmdPulse reset to 0.
- R10: PSLVERR is 0 for every access to a mapped offset and is never 1 outside an access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and bank clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address of the transfer |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write strobes |
| prdata | output | DATA_W | Read data, zero outside valid reads |
| pready | output | 1 | Always high, no wait states |
| pslverr | output | 1 | Error response for unmapped offsets |
| hwStatus | input | DATA_W | Hardware status value sampled each cycle |
| hwEvent | input | EVENT_W | Hardware event inputs that set flag bits |
| ctrlOut | output | DATA_W | Current control word for the hardware |
| cmdPulse | output | 1 | Single-cycle start pulse |
| irq | output | 1 | OR of all flag bits |

## Verification
The bench builds the block with DATA_W = 32, ADDR_W = 12, EVENT_W = 8 and a non-zero CTRL_RESET. Four strobe lanes allow partial-lane merges into the control word, flag clears on unstrobed lanes, and a command write whose pulse bit lies in an unstrobed lane. The 12-bit address window puts offsets such as 0x10 and misaligned addresses in reach of the error path. The eight event bits leave 24 upper flag bits that must read as zero. The bench also lines up an event with a clear of the same bit, and with a clear of a different bit, in the same access phase.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  // Register chosen by address bits [3:2]
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_FLAG   = 2'd2,
    SEL_CMD    = 2'd3
  } regSel_t;

  // Strobes handed from the bus glue to the bank
  typedef struct packed {
    logic    wrCtrl;
    logic    wrFlag;
    logic    wrCmd;
    logic    rdEn;
    regSel_t rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/csr_bus_ctrl.sv
module csr_bus_ctrl
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [DATA_W-1:0] ctrlQ,
  output bankStrobe_t       strobe,
  output logic [DATA_W-1:0] mergedData,
  output logic              slvErr
);
  localparam int LANES = DATA_W / 8;

  logic              accessPhase;
  logic              addrHit;
  regSel_t           sel;
  logic [DATA_W-1:0] laneMask;

  assign accessPhase = psel && penable;
  // Word-aligned and inside the four-register window
  assign addrHit = (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:4] == '0);
  assign sel     = regSel_t'(paddr[3:2]);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign laneMask[gi*8 +: 8] = {8{pstrb[gi]}};
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = sel;
    strobe.rdEn   = accessPhase && !pwrite && addrHit;
    if (accessPhase && pwrite && addrHit) begin
      case (sel)
        SEL_CTRL: strobe.wrCtrl = 1'b1;
        SEL_FLAG: strobe.wrFlag = 1'b1;
        SEL_CMD:  strobe.wrCmd  = 1'b1;
        default:  ; // status is hardware-owned: no strobe
      endcase
    end
  end

  // Unstrobed lanes keep the stored control bytes; elsewhere they read as zero
  assign mergedData = strobe.wrCtrl ? ((pwdata & laneMask) | (ctrlQ & ~laneMask))
                                    : (pwdata & laneMask);

  assign slvErr = accessPhase && !addrHit;

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          EVENT_W    = 8,
  parameter logic [DATA_W-1:0] CTRL_RESET = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  bankStrobe_t        strobe,
  input  logic [DATA_W-1:0]  mergedData,
  input  logic [DATA_W-1:0]  hwStatus,
  input  logic [EVENT_W-1:0] hwEvent,
  output logic [DATA_W-1:0]  ctrlQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               cmdPulse,
  output logic               irq
);
  logic [DATA_W-1:0]  statusQ;
  logic [EVENT_W-1:0] flagQ;
  logic [EVENT_W-1:0] clrMask;

  // Software-owned control storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlQ <= CTRL_RESET;
    else if (strobe.wrCtrl) ctrlQ <= mergedData;
  end

  // Hardware-owned status: no bus path reaches it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= hwStatus;
  end

  // Jointly owned flags: clear first, then hardware set overrides
  assign clrMask = strobe.wrFlag ? mergedData[EVENT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrMask) | hwEvent;
  end

  // Command strobe register: bit 0 launches the pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdPulse <= 1'b0;
    else       cmdPulse <= strobe.wrCmd && mergedData[0];
  end

  assign irq = |flagQ;

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) begin
      case (strobe.rdSel)
        SEL_CTRL:   rdData = ctrlQ;
        SEL_STATUS: rdData = statusQ;
        SEL_FLAG:   rdData = DATA_W'(flagQ);
        default:    rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/csr_slave.sv
module csr_slave
  import csr_bank_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          EVENT_W    = 8,
  parameter logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0101
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  output logic                pslverr,
  input  logic [DATA_W-1:0]   hwStatus,
  input  logic [EVENT_W-1:0]  hwEvent,
  output logic [DATA_W-1:0]   ctrlOut,
  output logic                cmdPulse,
  output logic                irq
);
  bankStrobe_t       strobe;
  logic [DATA_W-1:0] mergedData;
  logic [DATA_W-1:0] ctrlQ;

  csr_bus_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_bus_ctrl (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pstrb     (pstrb),
    .ctrlQ     (ctrlQ),
    .strobe    (strobe),
    .mergedData(mergedData),
    .slvErr    (pslverr)
  );

  csr_bank #(
    .DATA_W    (DATA_W),
    .EVENT_W   (EVENT_W),
    .CTRL_RESET(CTRL_RESET)
  ) i_bank (
    .clk       (pclk),
    .rstN      (presetn),
    .strobe    (strobe),
    .mergedData(mergedData),
    .hwStatus  (hwStatus),
    .hwEvent   (hwEvent),
    .ctrlQ     (ctrlQ),
    .rdData    (prdata),
    .cmdPulse  (cmdPulse),
    .irq       (irq)
  );

  assign pready  = 1'b1;
  assign ctrlOut = ctrlQ;

endmodule

// File: rtl/csr_slave_chk.sv
module csr_slave_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int EVENT_W = 8
) (
  input logic               pclk,
  input logic               presetn,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [DATA_W-1:0]  prdata,
  input logic               pslverr,
  input logic [EVENT_W-1:0] hwEvent,
  input logic [DATA_W-1:0]  ctrlOut,
  input logic               cmdPulse,
  input logic               irq
);
  logic busWrite, busRead;
  assign busWrite = psel && penable && pwrite;
  assign busRead  = psel && penable && !pwrite;

  assert_ctrl_hold_R1: assert property (@(posedge pclk) disable iff (!presetn)
    !(busWrite && paddr == ADDR_W'(0)) |=> $stable(ctrlOut));

  assert_event_wins_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (|hwEvent) |=> irq);

  assert_pulse_single_R6: assert property (@(posedge pclk) disable iff (!presetn)
    cmdPulse |=> !cmdPulse);

  assert_pulse_cause_R6: assert property (@(posedge pclk) disable iff (!presetn)
    cmdPulse |-> $past(busWrite && paddr == ADDR_W'(12)));

  assert_cmd_reads_zero_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (busRead && paddr == ADDR_W'(12)) |-> (prdata == '0 && !pslverr));

  assert_err_data_zero_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (busRead && pslverr) |-> prdata == '0);

  assert_err_phase_R10: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (psel && penable));

endmodule

bind csr_slave csr_slave_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .EVENT_W(EVENT_W)
) i_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .pslverr (pslverr),
  .hwEvent (hwEvent),
  .ctrlOut (ctrlOut),
  .cmdPulse(cmdPulse),
  .irq     (irq)
);

// File: tb/test_csr_slave.sv
`timescale 1ns/1ps
module test_csr_slave;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int EVENT_W = 8;
  localparam logic [DATA_W-1:0] CTRL_RST = 32'h0000_0101;

  logic                pclk = 1'b0;
  logic                presetn = 1'b0;
  logic                psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0]   paddr = '0;
  logic [DATA_W-1:0]   pwdata = '0;
  logic [DATA_W/8-1:0] pstrb = '0;
  logic [DATA_W-1:0]   prdata;
  logic                pready, pslverr;
  logic [DATA_W-1:0]   hwStatus = '0;
  logic [EVENT_W-1:0]  hwEvent = '0;
  logic [DATA_W-1:0]   ctrlOut;
  logic                cmdPulse, irq;

  int  checks = 0;
  int  errors = 0;
  logic wrErr;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              err;
    string             tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2 pclk = ~pclk;  // 250 MHz

  csr_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVENT_W(EVENT_W), .CTRL_RESET(CTRL_RST)
  ) i_csr_slave (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .hwStatus(hwStatus), .hwEvent(hwEvent), .ctrlOut(ctrlOut),
    .cmdPulse(cmdPulse), .irq(irq)
  );

  task automatic checkVal(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: compares every read access phase against the scoreboard
  always @(negedge pclk) begin
    expItem_t it;
    if (presetn && psel && penable && !pwrite) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected read actual=%h expected=none", prdata);
      end else begin
        it = expQ.pop_front();
        checkVal({it.tag, " prdata"}, prdata, it.data);
        checkVal({it.tag, " pslverr"}, DATA_W'(pslverr), DATA_W'(it.err));
        checkVal("R8 pready", DATA_W'(pready), 1);
      end
    end
  end

  task automatic apbWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                          logic [DATA_W/8-1:0] s, logic [EVENT_W-1:0] ev = '0);
    @(posedge pclk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; pstrb = s;
    @(posedge pclk); #1;
    penable = 1'b1; hwEvent = ev;
    @(negedge pclk);
    wrErr = pslverr;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; hwEvent = '0;
  endtask

  task automatic apbRead(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp,
                         logic expErr, string tag);
    expItem_t it;
    it.data = exp; it.err = expErr; it.tag = tag;
    expQ.push_back(it);
    @(posedge pclk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    checks++; errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge pclk);
    #1;
    // R9: reset state
    checkVal("R9 ctrlOut reset", ctrlOut, CTRL_RST);
    checkVal("R9 irq reset", DATA_W'(irq), 0);
    checkVal("R9 cmdPulse reset", DATA_W'(cmdPulse), 0);
    presetn = 1'b1;
    apbRead(12'h0, CTRL_RST, 1'b0, "R9");
    apbRead(12'h4, 32'h0, 1'b0, "R9");
    apbRead(12'h8, 32'h0, 1'b0, "R9");

    // R1: full and partial-lane control writes
    apbWrite(12'h0, 32'h1234_5678, 4'hF);
    checkVal("R1 ctrlOut full", ctrlOut, 32'h1234_5678);
    apbRead(12'h0, 32'h1234_5678, 1'b0, "R1");
    apbWrite(12'h0, 32'hAABB_CCDD, 4'b0101);
    checkVal("R10 write err", DATA_W'(wrErr), 0);
    apbRead(12'h0, 32'h12BB_56DD, 1'b0, "R1");

    // R8: setup phase alone commits nothing
    @(posedge pclk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = 12'h0; pwdata = 32'h0; pstrb = 4'hF;
    @(posedge pclk); #1;
    psel = 1'b0; pwrite = 1'b0;
    @(posedge pclk); #1;
    checkVal("R8 setup only", ctrlOut, 32'h12BB_56DD);

    // R2: status follows hardware, ignores writes
    hwStatus = 32'hCAFE_F00D;
    apbRead(12'h4, 32'hCAFE_F00D, 1'b0, "R2");
    apbWrite(12'h4, 32'hFFFF_FFFF, 4'hF);
    apbRead(12'h4, 32'hCAFE_F00D, 1'b0, "R2");
    hwStatus = 32'h0000_0001;
    apbRead(12'h4, 32'h0000_0001, 1'b0, "R2");

    // R5: events set flags, irq is their OR
    @(posedge pclk); #1; hwEvent = 8'h06;
    @(posedge pclk); #1; hwEvent = 8'h00;
    checkVal("R5 irq after event", DATA_W'(irq), 1);
    apbRead(12'h8, 32'h0000_0006, 1'b0, "R5");

    // R3: W1C with strobes, upper bits zero
    apbWrite(12'h8, 32'hFFFF_FF02, 4'b0001);
    apbRead(12'h8, 32'h0000_0004, 1'b0, "R3");
    apbWrite(12'h8, 32'h0000_0004, 4'b0000);
    apbRead(12'h8, 32'h0000_0004, 1'b0, "R3");
    apbWrite(12'h8, 32'h0000_0004, 4'b0001);
    apbRead(12'h8, 32'h0000_0000, 1'b0, "R3");
    checkVal("R3 irq cleared", DATA_W'(irq), 0);

    // R4: coincident event and clear on the same bit
    @(posedge pclk); #1; hwEvent = 8'h01;
    @(posedge pclk); #1; hwEvent = 8'h00;
    apbWrite(12'h8, 32'h0000_0001, 4'hF, 8'h01);
    checkVal("R4 irq after collision", DATA_W'(irq), 1);
    apbRead(12'h8, 32'h0000_0001, 1'b0, "R4");
    apbWrite(12'h8, 32'h0000_0001, 4'hF, 8'h02);
    apbRead(12'h8, 32'h0000_0002, 1'b0, "R4");
    apbWrite(12'h8, 32'h0000_0002, 4'hF);
    checkVal("R4 irq final", DATA_W'(irq), 0);

    // R6: command pulse
    apbWrite(12'hC, 32'h0000_0001, 4'hF);
    checkVal("R6 pulse high", DATA_W'(cmdPulse), 1);
    @(posedge pclk); #1;
    checkVal("R6 pulse one cycle", DATA_W'(cmdPulse), 0);
    apbWrite(12'hC, 32'h0000_0000, 4'hF);
    checkVal("R6 no pulse bit0 zero", DATA_W'(cmdPulse), 0);
    apbWrite(12'hC, 32'h0000_0001, 4'b1110);
    checkVal("R6 no pulse unstrobed", DATA_W'(cmdPulse), 0);
    apbRead(12'hC, 32'h0, 1'b0, "R6");

    // R7: unmapped and misaligned offsets
    apbWrite(12'h010, 32'hDEAD_BEEF, 4'hF);
    checkVal("R7 write err", DATA_W'(wrErr), 1);
    checkVal("R7 ctrl untouched", ctrlOut, 32'h12BB_56DD);
    apbWrite(12'h006, 32'hDEAD_BEEF, 4'hF);
    checkVal("R7 misaligned err", DATA_W'(wrErr), 1);
    checkVal("R7 ctrl untouched 2", ctrlOut, 32'h12BB_56DD);
    apbRead(12'h010, 32'h0, 1'b1, "R7");
    apbRead(12'h002, 32'h0, 1'b1, "R7");
    apbRead(12'h100, 32'h0, 1'b1, "R7");
    apbRead(12'h0, 32'h12BB_56DD, 1'b0, "R10");

    repeat (3) @(posedge pclk);
    checkVal("R7 scoreboard drained", DATA_W'(expQ.size()), 0);
    finishRun();
  end

endmodule